// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block is a small shared word memory with a reservation table, used by several processors to build lock-free read-modify-write sequences. A processor issues a load-exclusive to read a word and record that it holds that word. It later issues a store-exclusive, which writes only if the reservation survived. A store-exclusive whose reservation has been cancelled leaves memory untouched and reports failure, and software then repeats the sequence. Ordinary reads and writes share the same request port.

Requests arrive one per cycle on a single port tagged with the issuing processor's identifier. Every request gets exactly one response on the following cycle. The response carries the word as it stood before the request, and a status bit that is meaningful for store-exclusives.

Top module: `rsv_monitor`

## Requirements
- R1: After reset no response is pending, every memory word reads as zero, and no processor holds a reservation, so a store-exclusive issued right after reset fails.
- R2: Each request with reqValid high produces exactly one response one cycle later, with rspValid high, rspId equal to the requesting identifier, and rspData equal to the addressed word before the request; no response appears in a cycle after an idle cycle.
- R3: The operation code is 2 bits: 0 plain read, 1 plain write, 2 load-exclusive, 3 store-exclusive. A plain write always updates the word. rspStatus is 0 for any request that is not a store-exclusive.
- R4: A load-exclusive records a reservation for its processor on the addressed word; a later store-exclusive by the same processor to the same word, with no cancelling event between, writes the data and returns status 0 (success).
- R5: A store-exclusive from a processor that holds no reservation returns status 1 (failure) and leaves the word unchanged.
- R6: A plain write by another processor to a reserved word cancels that reservation, even when the written value equals the stored value; the holder's following store-exclusive fails and does not write.
- R7: Each processor holds at most one reservation; a new load-exclusive replaces the previous one, so a store-exclusive to the earlier word then fails.
- R8: A store-exclusive clears the issuing processor's reservation whether it succeeds or fails, so an immediately repeated store-exclusive fails.
- R9: A store-exclusive to a word other than the reserved one fails and does not write either word.
- R10: Reservations match on 4-byte-aligned words: address bits 1:0 are ignored, so a store-exclusive to a different byte of the reserved word succeeds.
- R11: A successful store-exclusive cancels other processors' reservations on the same word and leaves reservations on other words intact.
- R12: A plain write by a processor to its own reserved word does not cancel that processor's reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 2 | Operation code (0 read, 1 write, 2 load-exclusive, 3 store-exclusive) |
| reqId | input | ID_W | Issuing processor |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | DATA_W | Write data for write and store-exclusive |
| rspValid | output | 1 | Response present |
| rspId | output | ID_W | Processor the response belongs to |
| rspData | output | DATA_W | Word contents before the request |
| rspStatus | output | 1 | Store-exclusive outcome: 0 success, 1 failure |

## Verification
Directed sequences set up each way a reservation can end: an undisturbed pair, a foreign write of the same value, a replacement load-exclusive, a store-exclusive to another word, a repeated store-exclusive and a competing successful store-exclusive. Each sequence separates a monitor that tracks words from one that tracks processors or values. Reads after each failing store-exclusive show whether memory was touched. Byte-offset variants show whether matching happens on the word granule. A long pseudo-random mix of all four operations from four processors, concentrated on four words, then exposes interactions between reservations held on the same word.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_LDEX  = 2'd2,
    OP_STEX  = 2'd3
  } reqOp_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;   // register the addressed word into the response
    logic memWrite;  // commit write data to the addressed word
  } dpStrobe_t;
endpackage

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int ID_W   = 2,
  parameter int WIDX_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ID_W-1:0]   reqId,
  input  logic [WIDX_W-1:0] wordIdx,
  output dpStrobe_t         dpStb,
  output logic              rspValid,
  output logic [ID_W-1:0]   rspId,
  output logic              rspStatus
);
  logic [NPROC-1:0]  resValid;
  logic [WIDX_W-1:0] resAddr [NPROC];
  logic              ownHit;
  logic              isWrite, isLoadEx, isStoreEx;
  reqOp_t            opCode;

  always_comb begin
    opCode    = reqOp_t'(reqOp);
    isWrite   = (opCode == OP_WRITE);
    isLoadEx  = (opCode == OP_LDEX);
    isStoreEx = (opCode == OP_STEX);
    ownHit    = resValid[reqId] && (resAddr[reqId] == wordIdx);
    dpStb.capture  = reqValid;
    dpStb.memWrite = reqValid && (isWrite || (isStoreEx && ownHit));
  end

  // One reservation register per processor
  genvar g;
  generate
    for (g = 0; g < NPROC; g++) begin : g_res
      logic isOwner;
      logic foreignHit;
      assign isOwner    = (reqId == ID_W'(g));
      assign foreignHit = dpStb.memWrite && !isOwner && (resAddr[g] == wordIdx);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          resValid[g] <= 1'b0;
          resAddr[g]  <= '0;
        end else if (reqValid) begin
          if (isOwner && isLoadEx) begin
            resValid[g] <= 1'b1;
            resAddr[g]  <= wordIdx;
          end else if (isOwner && isStoreEx) begin
            resValid[g] <= 1'b0;
          end else if (foreignHit) begin
            resValid[g] <= 1'b0;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspId     <= '0;
      rspStatus <= 1'b0;
    end else begin
      rspValid  <= reqValid;
      rspId     <= reqId;
      rspStatus <= reqValid && isStoreEx && !ownHit;
    end
  end
endmodule

// File: rtl/rsv_datapath.sv
module rsv_datapath
  import rsv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WIDX_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dpStb,
  input  logic [WIDX_W-1:0] wordIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << WIDX_W;

  logic [DATA_W-1:0] memArr [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '0;
      rdData <= '0;
    end else begin
      if (dpStb.memWrite) memArr[wordIdx] <= wrData;
      if (dpStb.capture)  rdData <= memArr[wordIdx];
    end
  end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int ID_W   = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [ID_W-1:0]   rspId,
  output logic [DATA_W-1:0] rspData,
  output logic              rspStatus
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic              unusedOffsetBits;
  dpStrobe_t         dpStb;

  assign wordIdx          = reqAddr[ADDR_W-1:2];
  assign unusedOffsetBits = ^reqAddr[1:0];

  rsv_ctrl #(.NPROC(NPROC), .ID_W(ID_W), .WIDX_W(WIDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqId(reqId),
    .wordIdx(wordIdx), .dpStb(dpStb), .rspValid(rspValid), .rspId(rspId),
    .rspStatus(rspStatus)
  );

  rsv_datapath #(.DATA_W(DATA_W), .WIDX_W(WIDX_W)) u_data (
    .clk(clk), .rstN(rstN), .dpStb(dpStb), .wordIdx(wordIdx),
    .wrData(reqWdata), .rdData(rspData)
  );
endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqOp,
  input logic [ID_W-1:0]   reqId,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic [ID_W-1:0]   rspId,
  input logic              rspStatus,
  input logic              memWrite
);
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspValid && rspId == $past(reqId)));

  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_status_only_stex_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp != 2'd3) |=> !rspStatus);

  p_fail_no_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus) |-> !$past(memWrite));

  p_pair_passes_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid && reqOp == 2'd2) && reqValid && reqOp == 2'd3 &&
     reqId == $past(reqId) && reqAddr[ADDR_W-1:2] == $past(reqAddr[ADDR_W-1:2]))
    |=> !rspStatus);

  p_stex_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid && reqOp == 2'd3) && reqValid && reqOp == 2'd3 &&
     reqId == $past(reqId)) |=> rspStatus);
endmodule

bind rsv_monitor rsv_monitor_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqId(reqId),
  .reqAddr(reqAddr), .rspValid(rspValid), .rspId(rspId), .rspStatus(rspStatus),
  .memWrite(dpStb.memWrite)
);

// File: tb/rsv_monitor_test.sv
`timescale 1ns/1ps
module rsv_monitor_test;
  localparam int NPROC = 4, ID_W = 2, ADDR_W = 8, DATA_W = 32;
  localparam int DEPTH = 1 << (ADDR_W - 2);

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [ID_W-1:0] reqId = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic rspValid, rspStatus;
  logic [ID_W-1:0] rspId;
  logic [DATA_W-1:0] rspData;

  rsv_monitor #(.NPROC(NPROC), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqId(reqId),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid), .rspId(rspId),
    .rspData(rspData), .rspStatus(rspStatus)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [ID_W-1:0]   id;
    logic [DATA_W-1:0] data;
    logic              status;
    string             tag;
  } expItem_t;

  expItem_t expQ[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  // Reference state derived from the requirements
  logic [DATA_W-1:0] mMem [DEPTH];
  logic              mVal [NPROC];
  logic [ADDR_W-3:0] mAddr [NPROC];

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int id, input logic [ADDR_W-1:0] addr,
                       input logic [DATA_W-1:0] wd, input string tag);
    expItem_t it;
    logic [ADDR_W-3:0] w;
    bit hit, wr;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqId = ID_W'(id); reqAddr = addr; reqWdata = wd;
    w = addr[ADDR_W-1:2];
    it.id = ID_W'(id); it.data = mMem[w]; it.status = 1'b0; it.tag = tag;
    hit = mVal[id] && (mAddr[id] == w);
    wr = 0;
    case (op)
      2'd1: wr = 1;
      2'd2: begin mVal[id] = 1; mAddr[id] = w; end
      2'd3: begin it.status = !hit; wr = hit; mVal[id] = 0; end
      default: ;
    endcase
    if (wr) begin
      mMem[w] = wd;
      for (int p = 0; p < NPROC; p++)
        if (p != id && mAddr[p] == w) mVal[p] = 0;
    end
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // Monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(0, "R2 unexpected response", "rspValid=1", "none");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(rspId == e.id, {e.tag, " id"}, $sformatf("%0d", rspId), $sformatf("%0d", e.id));
        check(rspData == e.data, {e.tag, " data"}, $sformatf("%h", rspData), $sformatf("%h", e.data));
        check(rspStatus == e.status, {e.tag, " status"}, $sformatf("%0d", rspStatus), $sformatf("%0d", e.status));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    for (int p = 0; p < NPROC; p++) begin mVal[p] = 0; mAddr[p] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == 1'b0, "R1 reset response", $sformatf("%0d", rspValid), "0");

    // R1: reservations and memory clear after reset
    issue(2'd3, 0, 8'h10, 32'hDEAD0001, "R1 stex after reset");
    issue(2'd0, 0, 8'h10, 0, "R1 memory zero");
    // R3: plain write
    issue(2'd1, 1, 8'h20, 32'h1111_2222, "R3 write");
    issue(2'd0, 2, 8'h20, 0, "R3 readback");
    idle(1);
    // R4: undisturbed pair
    issue(2'd2, 0, 8'h20, 0, "R4 ldex");
    issue(2'd3, 0, 8'h20, 32'hAAAA_0004, "R4 stex pass");
    issue(2'd0, 3, 8'h20, 0, "R4 readback");
    // R5: no reservation
    issue(2'd3, 2, 8'h24, 32'h5555_5555, "R5 stex no reservation");
    issue(2'd0, 2, 8'h24, 0, "R5 word untouched");
    // R6: foreign write of the same value cancels
    issue(2'd2, 1, 8'h20, 0, "R6 ldex");
    issue(2'd1, 2, 8'h20, 32'hAAAA_0004, "R6 same-value write");
    issue(2'd3, 1, 8'h20, 32'h6666_6666, "R6 stex fail");
    issue(2'd0, 1, 8'h20, 0, "R6 word untouched");
    // R7: replacement
    issue(2'd2, 3, 8'h30, 0, "R7 ldex first");
    issue(2'd2, 3, 8'h34, 0, "R7 ldex second");
    issue(2'd3, 3, 8'h30, 32'h7777_7777, "R7 stex old word fails");
    issue(2'd2, 3, 8'h30, 0, "R7 ldex again");
    issue(2'd2, 3, 8'h34, 0, "R7 ldex replace");
    issue(2'd3, 3, 8'h34, 32'h7777_0034, "R7 stex new word passes");
    // R8: repeated store-exclusive
    issue(2'd2, 0, 8'h40, 0, "R8 ldex");
    issue(2'd3, 0, 8'h40, 32'h8888_0001, "R8 first stex");
    issue(2'd3, 0, 8'h40, 32'h8888_0002, "R8 second stex fails");
    issue(2'd0, 0, 8'h40, 0, "R8 readback");
    // R9: store-exclusive to another word
    issue(2'd2, 2, 8'h50, 0, "R9 ldex");
    issue(2'd3, 2, 8'h54, 32'h9999_9999, "R9 stex other word");
    issue(2'd0, 2, 8'h54, 0, "R9 other word untouched");
    issue(2'd3, 2, 8'h50, 32'h9999_0050, "R9 reservation cleared");
    // R10: byte offsets ignored
    issue(2'd2, 1, 8'h61, 0, "R10 ldex byte 1");
    issue(2'd3, 1, 8'h63, 32'h1010_1010, "R10 stex byte 3 passes");
    issue(2'd0, 1, 8'h60, 0, "R10 readback");
    // R11: competing successful stex
    issue(2'd2, 0, 8'h70, 0, "R11 ldex p0");
    issue(2'd2, 1, 8'h70, 0, "R11 ldex p1");
    issue(2'd2, 2, 8'h74, 0, "R11 ldex p2 other word");
    issue(2'd3, 1, 8'h70, 32'h1111_0070, "R11 p1 wins");
    issue(2'd3, 0, 8'h70, 32'h1111_0000, "R11 p0 loses");
    issue(2'd3, 2, 8'h74, 32'h1111_0074, "R11 p2 unaffected");
    // R12: own plain write keeps reservation
    issue(2'd2, 3, 8'h80, 0, "R12 ldex");
    issue(2'd1, 3, 8'h80, 32'h1212_0001, "R12 own write");
    issue(2'd3, 3, 8'h80, 32'h1212_0002, "R12 stex passes");
    issue(2'd0, 0, 8'h80, 0, "R12 readback");
    idle(2);

    // R2: pseudo-random mix on four contended words
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[9:8] == 2'd0) idle(1);
      else issue(lfsr[1:0], int'(lfsr[3:2]), {2'b10, 2'b00, lfsr[5:4], lfsr[7:6]},
                 {lfsr[15:0], lfsr[31:16]}, "R2 random mix");
    end
    idle(3);
    check(expQ.size() == 0, "R2 all responses seen", $sformatf("%0d", expQ.size()), "0");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule